// File: doc/BRIEF.md
# Accumulator Multicycle Processor Core

This block is a compact processor that keeps all computation in a single 16-bit accumulator and owns a private word-addressed memory of 4096 sixteen-bit words. Each instruction is one 16-bit word: an opcode in the top four bits and a 12-bit operand address below it. Execution walks a fixed register-transfer sequence. It moves the program counter into an address register, reads the word into an instruction register, then routes operand accesses through the address register and a buffer register before the accumulator changes.

A testbench or boot agent fills memory through a simple write port that is honoured only while reset is held. When reset is released, the core starts fetching at address 0. Byte-wide I/O is provided by an input port with a valid strobe, which the input instruction waits on, and an output port with a one-cycle write strobe. A halted flag reports that the program has stopped.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high, a cycle with `ld_en` high writes `ld_data` to memory word `ld_addr`. During reset `out_data` reads 0 and `out_strobe` and `halted` read 0. On release, AC is 0 and the first instruction is fetched from address 0.
- R2: An instruction holds its opcode in bits 15:12 and its address X in bits 11:0. Opcode 1 (LOAD) copies M[X] into AC. Opcode 2 (STORE) writes AC into M[X].
- R3: Opcode 3 (ADD) sets AC to AC + M[X] and opcode 4 (SUBT) sets AC to AC - M[X], both in two's complement, wrapping modulo 2^16.
- R4: Opcode B (ADDI) reads M[X], uses its bits 11:0 as an address Y, and adds M[Y] to AC modulo 2^16.
- R5: Opcode 8 (SKIPCOND) tests AC using instruction bits 11:10. With 00 it skips the next instruction when AC is negative. With 01 it skips when AC is zero. With 10 it skips when AC is positive. With 11 it never skips.
- R6: Opcode 9 (JUMP) continues execution at X. Opcode C (JUMPI) continues at bits 11:0 of M[X].
- R7: Opcode 5 (INPUT) waits until `in_valid` is high, then loads `in_data` zero-extended into AC. `in_valid` pulses outside that wait change nothing.
- R8: Opcode 6 (OUTPUT) drives AC bits 7:0 on `out_data` with `out_strobe` high for exactly one cycle. `out_data` keeps that value until the next OUTPUT or reset.
- R9: Opcode A (CLEAR) sets AC to 0. Opcodes 0, D, E and F leave AC and memory unchanged and fall through to the next address.
- R10: Opcode 7 (HALT) raises `halted`. After that, no output strobe occurs and no register changes until reset.
- R11: The program counter wraps modulo 4096, so the word after address 0xFFF is fetched from address 0x000.
- R12: `ld_en` has no effect while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the load port |
| in_data | input | 8 | Input byte for INPUT |
| in_valid | input | 1 | Input byte is valid this cycle |
| out_data | output | 8 | Last byte written by OUTPUT |
| out_strobe | output | 1 | One-cycle pulse when `out_data` is updated |
| halted | output | 1 | Core has executed HALT |
| ld_en | input | 1 | Memory preload write enable (honoured only in reset) |
| ld_addr | input | 12 | Memory preload word address |
| ld_data | input | 16 | Memory preload word |

## Verification
Two cases can land in the same cycle: a stray input strobe or load-port write arriving while the core is busy with another instruction. The bench provokes this by pulsing `in_valid` with a decoy byte and driving `ld_en` at a data word during the first cycles of a run, while a LOAD is still executing. It judges the result at the ports. The byte later emitted by OUTPUT must be the one supplied during the real INPUT wait, and a LOAD of the targeted word must output its preloaded value. A scoreboard queue holds the ordered bytes each program should emit and compares them against every strobe. Any extra strobe from a skip that failed to skip, or from code that should not run, shows up as a miscompare.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_LOAD   = 4'h1;
   localparam logic [OPC_W-1:0] OP_STORE  = 4'h2;
   localparam logic [OPC_W-1:0] OP_ADD    = 4'h3;
   localparam logic [OPC_W-1:0] OP_SUBT   = 4'h4;
   localparam logic [OPC_W-1:0] OP_INPUT  = 4'h5;
   localparam logic [OPC_W-1:0] OP_OUTPUT = 4'h6;
   localparam logic [OPC_W-1:0] OP_HALT   = 4'h7;
   localparam logic [OPC_W-1:0] OP_SKIP   = 4'h8;
   localparam logic [OPC_W-1:0] OP_JUMP   = 4'h9;
   localparam logic [OPC_W-1:0] OP_CLEAR  = 4'hA;
   localparam logic [OPC_W-1:0] OP_ADDI   = 4'hB;
   localparam logic [OPC_W-1:0] OP_JUMPI  = 4'hC;

   // sequencer steps
   typedef enum logic [3:0] {
      ST_F1,    // address register <- program counter
      ST_F2,    // instruction register <- memory, PC advance
      ST_DEC,   // decode, single-step instructions finish here
      ST_RD,    // buffer <- memory[address]
      ST_EX,    // accumulator update / indirect setup
      ST_RD2,   // second operand read for indirect add
      ST_EX2,   // indirect add completes
      ST_WR,    // memory[address] <- buffer
      ST_IN,    // wait for input byte
      ST_HALT
   } state_e;

   typedef enum logic [1:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB
   } alu_op_e;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_chk_depth
      $error("acc_cpu_mem: ADDR_W out of supported range");
   end

   logic [DATA_W-1:0] words_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words_q[waddr] <= wdata;
   end

   assign rdata = words_q[raddr];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   if (DATA_W < 2) begin : g_chk_w
      $error("acc_cpu_alu: DATA_W too small");
   end

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         default: y = b;
      endcase
   end

endmodule

// File: rtl/acc_cpu_skip.sv
module acc_cpu_skip #(
   parameter int DATA_W = 16,
   parameter int SEL_W  = 2
) (
   input  logic [DATA_W-1:0] ac,
   input  logic [SEL_W-1:0]  sel,
   output logic              take
);
   if (SEL_W != 2) begin : g_chk_sel
      $error("acc_cpu_skip: condition field must be 2 bits");
   end

   logic neg, zero;
   assign neg  = ac[DATA_W-1];
   assign zero = (ac == '0);

   always_comb begin
      unique case (sel)
         2'b00:   take = neg;
         2'b01:   take = zero;
         2'b10:   take = !neg && !zero;
         default: take = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int IO_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IO_W-1:0]   in_data,
   input  logic              in_valid,
   output logic [IO_W-1:0]   out_data,
   output logic              out_strobe,
   output logic              halted,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data
);
   localparam int CND_W   = 2;
   localparam int CND_LSB = ADDR_W - CND_W;
   localparam int PAD_W   = DATA_W - IO_W;

   if (OPC_W + ADDR_W > DATA_W) begin : g_chk_fmt
      $error("acc_cpu_core: opcode and address do not fit in a word");
   end
   if (IO_W >= DATA_W) begin : g_chk_io
      $error("acc_cpu_core: I/O width must be narrower than the word");
   end
   if (ADDR_W <= CND_W) begin : g_chk_cnd
      $error("acc_cpu_core: address field too narrow for condition");
   end

   state_e            st_q;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] mbr_q, ir_q, ac_q;
   logic [IO_W-1:0]   outreg_q;
   logic              ostb_q;

   logic [OPC_W-1:0]  opc;
   assign opc = ir_q[DATA_W-1 -: OPC_W];

   // memory: preload port owns the write side only during reset
   logic              mem_we;
   logic [ADDR_W-1:0] mem_wa;
   logic [DATA_W-1:0] mem_wd, mem_rd;

   assign mem_we = rst ? ld_en   : (st_q == ST_WR);
   assign mem_wa = rst ? ld_addr : mar_q;
   assign mem_wd = rst ? ld_data : mbr_q;

   acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_wa),
      .wdata (mem_wd),
      .raddr (mar_q),
      .rdata (mem_rd)
   );

   alu_op_e           alu_op;
   logic [DATA_W-1:0] alu_y;

   always_comb begin
      if (st_q == ST_EX2)        alu_op = ALU_ADD;
      else if (opc == OP_ADD)    alu_op = ALU_ADD;
      else if (opc == OP_SUBT)   alu_op = ALU_SUB;
      else                       alu_op = ALU_PASS;
   end

   acc_cpu_alu #(.DATA_W(DATA_W)) i_alu (
      .op (alu_op),
      .a  (ac_q),
      .b  (mbr_q),
      .y  (alu_y)
   );

   logic skip_take;

   acc_cpu_skip #(.DATA_W(DATA_W), .SEL_W(CND_W)) i_skip (
      .ac   (ac_q),
      .sel  (ir_q[CND_LSB +: CND_W]),
      .take (skip_take)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_F1;
         pc_q     <= '0;
         mar_q    <= '0;
         mbr_q    <= '0;
         ir_q     <= '0;
         ac_q     <= '0;
         outreg_q <= '0;
         ostb_q   <= 1'b0;
      end else begin
         ostb_q <= 1'b0;
         unique case (st_q)
            ST_F1: begin
               mar_q <= pc_q;
               st_q  <= ST_F2;
            end
            ST_F2: begin
               ir_q <= mem_rd;
               pc_q <= pc_q + 1'b1;
               st_q <= ST_DEC;
            end
            ST_DEC: begin
               mar_q <= ir_q[ADDR_W-1:0];
               st_q  <= ST_F1;
               case (opc)
                  OP_LOAD, OP_ADD, OP_SUBT, OP_ADDI, OP_JUMPI: st_q <= ST_RD;
                  OP_STORE: begin
                     mbr_q <= ac_q;
                     st_q  <= ST_WR;
                  end
                  OP_INPUT:  st_q <= ST_IN;
                  OP_OUTPUT: begin
                     outreg_q <= ac_q[IO_W-1:0];
                     ostb_q   <= 1'b1;
                  end
                  OP_HALT:   st_q <= ST_HALT;
                  OP_SKIP:   if (skip_take) pc_q <= pc_q + 1'b1;
                  OP_JUMP:   pc_q <= ir_q[ADDR_W-1:0];
                  OP_CLEAR:  ac_q <= '0;
                  default: ;
               endcase
            end
            ST_RD: begin
               mbr_q <= mem_rd;
               st_q  <= ST_EX;
            end
            ST_EX: begin
               st_q <= ST_F1;
               case (opc)
                  OP_ADDI: begin
                     mar_q <= mbr_q[ADDR_W-1:0];
                     st_q  <= ST_RD2;
                  end
                  OP_JUMPI: pc_q <= mbr_q[ADDR_W-1:0];
                  default:  ac_q <= alu_y;
               endcase
            end
            ST_RD2: begin
               mbr_q <= mem_rd;
               st_q  <= ST_EX2;
            end
            ST_EX2: begin
               ac_q <= alu_y;
               st_q <= ST_F1;
            end
            ST_WR: st_q <= ST_F1;
            ST_IN: begin
               if (in_valid) begin
                  ac_q <= {{PAD_W{1'b0}}, in_data};
                  st_q <= ST_F1;
               end
            end
            ST_HALT: ;
            default: st_q <= ST_F1;
         endcase
      end
   end

   assign out_data   = outreg_q;
   assign out_strobe = ostb_q;
   assign halted     = (st_q == ST_HALT);

   // R8: strobe lasts a single cycle
   a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
      out_strobe |=> !out_strobe);

   // R10: halt is sticky and freezes architectural state
   a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted && $stable(ac_q) && $stable(pc_q) && $stable(out_data));

   a_r10_no_strobe_halted: assert property (@(posedge clk) disable iff (rst)
      halted |-> !out_strobe);

   // R11: every fetch advances the counter by one, modulo the address space
   a_r11_pc_step: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_F2) |=> (pc_q == $past(pc_q) + 1'b1));

   // R2: fetch addresses memory from the program counter
   a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_F1) |=> (mar_q == $past(pc_q)));

   // R7: without a valid byte the input wait keeps AC untouched
   a_r7_input_wait: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IN && !in_valid) |=> (st_q == ST_IN) && $stable(ac_q));

endmodule

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  out_data;
   logic        out_strobe;
   logic        halted;
   logic        ld_en = 1'b0;
   logic [11:0] ld_addr = '0;
   logic [15:0] ld_data = '0;

   always #4 clk = ~clk;   // 125 MHz

   acc_cpu_core i_acc_cpu_core (
      .clk        (clk),
      .rst        (rst),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .out_data   (out_data),
      .out_strobe (out_strobe),
      .halted     (halted),
      .ld_en      (ld_en),
      .ld_addr    (ld_addr),
      .ld_data    (ld_data)
   );

   int vectors = 0;
   int errors  = 0;

   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t mon_e;
   logic prev_stb = 1'b0;

   task automatic check(input bit ok, input string tag,
                        input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_out(input logic [7:0] v, input string tag);
      exp_q.push_back('{v, tag});
   endtask

   // monitor: compare each output strobe with the next scoreboard item
   always @(negedge clk) begin
      if (!rst) begin
         if (out_strobe) begin
            if (prev_stb) check(1'b0, "R8 strobe wider than one cycle", 16'd1, 16'd0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 unexpected output strobe", {8'h0, out_data}, 16'h0);
            end else begin
               mon_e = exp_q.pop_front();
               check(out_data == mon_e.v, mon_e.tag, {8'h0, out_data}, {8'h0, mon_e.v});
            end
         end
         prev_stb = out_strobe;
      end else begin
         prev_stb = 1'b0;
      end
   end

   task automatic begin_prog();
      rst      = 1'b1;
      in_valid = 1'b0;
      ld_en    = 1'b0;
      repeat (2) @(negedge clk);
      check(halted == 1'b0 && out_strobe == 1'b0 && out_data == 8'h00,
            "R1 reset outputs", {out_data, 6'h0, out_strobe, halted}, 16'h0);
   endtask

   task automatic put(input logic [11:0] a, input logic [15:0] d);
      ld_en   = 1'b1;
      ld_addr = a;
      ld_data = d;
      @(negedge clk);
      ld_en   = 1'b0;
   endtask

   task automatic run(input string tag);
      int n;
      rst = 1'b0;
      n = 0;
      while (!halted && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check(halted == 1'b1, {tag, " R10 reached halt"}, {15'h0, halted}, 16'h1);
      check(exp_q.size() == 0, {tag, " all outputs seen"}, 16'(exp_q.size()), 16'h0);
      exp_q.delete();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] held;

      // ---- program 1: load/store, add/subtract wrap, clear, undefined opcodes
      begin_prog();
      put(12'h000, 16'h6000); expect_out(8'h00, "R1 AC zero after reset");
      put(12'h001, 16'h1100);
      put(12'h002, 16'h3101);
      put(12'h003, 16'h6000); expect_out(8'h46, "R3 add");
      put(12'h004, 16'h4102);
      put(12'h005, 16'h6000); expect_out(8'hF6, "R3 subtract below zero");
      put(12'h006, 16'h2103);
      put(12'h007, 16'hA000);
      put(12'h008, 16'h6000); expect_out(8'h00, "R9 clear");
      put(12'h009, 16'h1103);
      put(12'h00A, 16'h6000); expect_out(8'hF6, "R2 store then load");
      put(12'h00B, 16'hD000);
      put(12'h00C, 16'h0FFF);
      put(12'h00D, 16'h3104);
      put(12'h00E, 16'h6000); expect_out(8'h02, "R3 R9 wrap add after no-ops");
      put(12'h00F, 16'h7000);
      put(12'h100, 16'h0012);
      put(12'h101, 16'h0034);
      put(12'h102, 16'h0050);
      put(12'h103, 16'h0000);
      put(12'h104, 16'h000C);
      run("P1");
      check(out_data == 8'h02, "R8 out_data holds after strobe", {8'h0, out_data}, 16'h02);
      held = out_data;
      repeat (5) @(negedge clk);
      in_data = 8'h55; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (15) @(negedge clk);
      check(halted == 1'b1 && out_data == held, "R10 frozen after halt",
            {out_data, 7'h0, halted}, {held, 8'h01});

      // ---- program 2: indirect add, jump, indirect jump
      begin_prog();
      put(12'h000, 16'hB020);
      put(12'h001, 16'h6000); expect_out(8'h07, "R4 indirect add");
      put(12'h002, 16'hB020);
      put(12'h003, 16'h6000); expect_out(8'h0E, "R4 indirect add accumulates");
      put(12'h004, 16'h9010);
      put(12'h005, 16'h7000);
      put(12'h010, 16'hC021);
      put(12'h011, 16'h7000);
      put(12'h020, 16'h0030);
      put(12'h021, 16'h0040);
      put(12'h022, 16'h005A);
      put(12'h030, 16'h0007);
      put(12'h040, 16'h1022);
      put(12'h041, 16'h6000); expect_out(8'h5A, "R6 jump then indirect jump");
      put(12'h042, 16'h7000);
      run("P2");

      // ---- program 3: every skip condition, taken and not taken
      begin_prog();
      put(12'h000, 16'h1050);
      put(12'h001, 16'h8000);
      put(12'h002, 16'h6000);
      put(12'h003, 16'h8400);
      put(12'h004, 16'h6000); expect_out(8'hFF, "R5 zero test on negative");
      put(12'h005, 16'h8800);
      put(12'h006, 16'h6000); expect_out(8'hFF, "R5 positive test on negative");
      put(12'h007, 16'h1051);
      put(12'h008, 16'h8800);
      put(12'h009, 16'h6000);
      put(12'h00A, 16'h8000);
      put(12'h00B, 16'h6000); expect_out(8'h03, "R5 negative test on positive");
      put(12'h00C, 16'hA000);
      put(12'h00D, 16'h8400);
      put(12'h00E, 16'h6000);
      put(12'h00F, 16'h8C00);
      put(12'h010, 16'h6000); expect_out(8'h00, "R5 condition 11 never skips");
      put(12'h011, 16'h8000);
      put(12'h012, 16'h6000); expect_out(8'h00, "R5 negative test on zero");
      put(12'h013, 16'h7000);
      put(12'h050, 16'hFFFF);
      put(12'h051, 16'h0003);
      run("P3");

      // ---- program 4: count-down loop left through the negative test
      begin_prog();
      put(12'h000, 16'h1040);
      put(12'h001, 16'h6000);
      put(12'h002, 16'h4041);
      put(12'h003, 16'h8000);
      put(12'h004, 16'h9001);
      put(12'h005, 16'h7000);
      put(12'h040, 16'h0003);
      put(12'h041, 16'h0001);
      expect_out(8'h03, "R5 loop pass 3");
      expect_out(8'h02, "R5 loop pass 2");
      expect_out(8'h01, "R5 loop pass 1");
      expect_out(8'h00, "R5 loop pass 0");
      run("P4");

      // ---- program 5: input wait, stray strobes and load-port writes while running
      begin_prog();
      put(12'h000, 16'h1060);
      put(12'h001, 16'h5000);
      put(12'h002, 16'h6000); expect_out(8'hC3, "R7 input byte");
      put(12'h003, 16'h3061);
      put(12'h004, 16'h8000);
      put(12'h005, 16'h7000);
      put(12'h006, 16'h1070);
      put(12'h007, 16'h6000); expect_out(8'h11, "R12 load port ignored while running");
      put(12'h008, 16'h7000);
      put(12'h060, 16'h1234);
      put(12'h061, 16'hFF00);
      put(12'h070, 16'h0011);
      fork
         run("P5 R7 R12");
         begin
            wait (rst == 1'b0);
            @(negedge clk);
            in_data = 8'h77; in_valid = 1'b1;
            ld_en = 1'b1; ld_addr = 12'h070; ld_data = 16'h00EE;
            @(negedge clk);
            in_valid = 1'b0; ld_en = 1'b0;
            repeat (30) @(negedge clk);
            in_data = 8'hC3; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
         end
      join

      // ---- program 6: program counter wrap from the top address
      begin_prog();
      put(12'h000, 16'h8400);
      put(12'h001, 16'h7000);
      put(12'h002, 16'h10F0);
      put(12'h003, 16'h9FFF);
      put(12'h0F0, 16'h0033);
      put(12'hFFF, 16'h6000); expect_out(8'h33, "R11 execute top address");
      run("P6 R11");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule